// File: doc/BRIEF.md
# Multiplexed Bus Register File Interface

This block connects a host to a 128-byte space made of 14 clock, alarm and control bytes and 114 bytes of user RAM. Address and data share one 8-bit bus. The host sends the address, drops the address strobe, then completes the access with an active-low read strobe or an active-low write strobe. Chip select must be low for the access to take effect. All host pins are synchronised to the system clock, and the logic acts on edges of the synchronised copies.

A separate update port lets the clock-counting logic write any clock byte, including the bits the host cannot change. All 14 clock bytes are presented continuously on a flat output vector. A power-good input gates the whole host interface. While it is low, and for a set number of cycles after it rises, the bus is ignored and the data output stays undriven. A clear input fills the user RAM with ones.

Top module: `mux_bus_regfile`

## Requirements
- R1: After reset every byte reads 0x00, `ad_oe_o` is low and `clk_regs_o` is all zero.
- R2: The falling edge of the synchronised address strobe latches bits 6:0 of the bus as the address. Bit 7 is discarded, so bus value 0x85 selects location 0x05.
- R3: A write takes the bus byte when the synchronised write strobe rises with chip select low. A later read of the same location returns that byte.
- R4: During a read with chip select low, `ad_oe_o` is high and `ad_o` shows the addressed byte. With chip select high, `ad_oe_o` stays low and a write has no effect.
- R5: An address cycle with chip select high still latches the address. A following strobe with chip select low accesses that latched location.
- R6: Host writes to locations 12 and 13 are dropped. Bit 7 of locations 0 and 10 keeps its old value on a host write, while bits 6:0 are written.
- R7: An update-port write to a location 0..13 stores the full byte, including bits the host cannot write. A host write to the same location in the same cycle takes priority.
- R8: `clk_regs_o[8*i+7:8*i]` always holds location i, for i = 0..13.
- R9: While `pwr_good_i` is low the host bus is ignored: no address latch, no write, and `ad_oe_o` stays low.
- R10: After `pwr_good_i` rises, access stays blocked for `PWR_DELAY_CYC` cycles.
- R11: While `ram_clr_i` is high, every byte at locations 14..127 becomes 0xFF. Locations 0..13 are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Supply good; low blocks the host bus |
| ram_clr_i | input | 1 | Fill the user RAM with 0xFF while high |
| ad_i | input | 8 | Multiplexed address/data bus, inbound |
| ad_o | output | 8 | Read data, outbound |
| ad_oe_o | output | 1 | Output enable for `ad_o` |
| as_i | input | 1 | Address strobe; the address latches on its falling edge |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| cs_ni | input | 1 | Chip select, active low |
| upd_we_i | input | 1 | Update-port write enable |
| upd_addr_i | input | 4 | Update-port location (0..13) |
| upd_data_i | input | 8 | Update-port data |
| clk_regs_o | output | 112 | Clock bytes 0..13, byte i at bits 8*i+7:8*i |

## Verification
The bench writes 0xFF to the read-only locations and to the bytes with a read-only bit 7. A design without the masks would show those bits set on `clk_regs_o`. It issues an address with chip select high, then a strobe with chip select low. A design that latched the address only under chip select would write to the stale address. It sends bus value 0x85 to catch a design that keeps 8 address bits. It also writes while power is bad and during the start-up hold-off, where a missing gate or a short counter would let data through. Finally it clears the RAM after programming the clock bytes, where a clear that ran too far would overwrite them.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  localparam int unsigned NUM_BYTES = 128;
  localparam int unsigned CLK_BYTES = 14;
  localparam int unsigned AW        = $clog2(NUM_BYTES);
  localparam int unsigned UAW       = $clog2(CLK_BYTES);

  // host-writable bits per location
  function automatic logic [7:0] host_wmask(input logic [AW-1:0] a);
    case (a)
      7'd12, 7'd13: return 8'h00;
      7'd0,  7'd10: return 8'h7f;
      default:      return 8'hff;
    endcase
  endfunction
endpackage

// File: rtl/mbr_sync.sv
module mbr_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
      s3_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign q_o    = s2_q;
  assign prev_o = s3_q;
endmodule

// File: rtl/mbr_pwr_gate.sv
module mbr_pwr_gate #(
  parameter int unsigned DELAY_CYC = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  output logic ok_o
);
  localparam int unsigned CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DELAY_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ok_o  <= 1'b0;
    end else if (!pwr_good_i) begin
      cnt_q <= '0;
      ok_o  <= 1'b0;
    end else if (cnt_q == LIMIT) begin
      ok_o  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9
  pg_low_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> !ok_o);
  // R10
  ok_needs_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_o) |-> $past(cnt_q) == LIMIT);
endmodule

// File: rtl/mbr_store.sv
module mbr_store
  import mbr_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   host_we_i,
  input  logic [AW-1:0]          host_addr_i,
  input  logic [7:0]             host_data_i,
  input  logic                   upd_we_i,
  input  logic [UAW-1:0]         upd_addr_i,
  input  logic [7:0]             upd_data_i,
  output logic [7:0]             rdata_o,
  output logic [CLK_BYTES*8-1:0] clk_regs_o
);
  logic [7:0] mem_q [NUM_BYTES];
  logic [7:0] wmask;

  assign wmask = host_wmask(host_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BYTES; i++) mem_q[i] <= 8'h00;
    end else begin
      if (upd_we_i && upd_addr_i < UAW'(CLK_BYTES))
        mem_q[AW'(upd_addr_i)] <= upd_data_i;
      if (host_we_i)
        mem_q[host_addr_i] <= (mem_q[host_addr_i] & ~wmask) | (host_data_i & wmask);
      if (clr_i)
        for (int i = CLK_BYTES; i < NUM_BYTES; i++) mem_q[i] <= 8'hff;
    end
  end

  assign rdata_o = mem_q[host_addr_i];

  for (genvar g = 0; g < CLK_BYTES; g++) begin : g_out
    assign clk_regs_o[g*8 +: 8] = mem_q[g];
  end

  // R6
  ro_c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_addr_i == 7'd12 && !(upd_we_i && upd_addr_i == 4'd12))
      |=> $stable(mem_q[12]));
  // R11
  clr_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (mem_q[CLK_BYTES] == 8'hff && mem_q[NUM_BYTES-1] == 8'hff));
  // R11
  clr_keeps_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !upd_we_i && !host_we_i) |=> $stable(mem_q[CLK_BYTES-1]));
endmodule

// File: rtl/mux_bus_regfile.sv
module mux_bus_regfile
  import mbr_pkg::*;
#(
  parameter int unsigned PWR_DELAY_CYC = 10_000_000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pwr_good_i,
  input  logic                   ram_clr_i,
  input  logic [7:0]             ad_i,
  output logic [7:0]             ad_o,
  output logic                   ad_oe_o,
  input  logic                   as_i,
  input  logic                   rd_ni,
  input  logic                   wr_ni,
  input  logic                   cs_ni,
  input  logic                   upd_we_i,
  input  logic [UAW-1:0]         upd_addr_i,
  input  logic [7:0]             upd_data_i,
  output logic [CLK_BYTES*8-1:0] clk_regs_o
);
  // strobe order: {as, rd_n, wr_n, cs_n}
  logic [3:0] stb_s, stb_p;
  logic [7:0] ad_s, ad_p;
  logic       ok;
  logic [AW-1:0] addr_q;
  logic       as_fall, wr_rise, cs_act, host_we;
  logic [7:0] rdata;

  mbr_sync #(.W(4), .RST_VAL(4'b0111)) u_stb (
    .clk_i, .rst_ni, .d_i({as_i, rd_ni, wr_ni, cs_ni}), .q_o(stb_s), .prev_o(stb_p));

  mbr_sync #(.W(8), .RST_VAL(8'h00)) u_ad (
    .clk_i, .rst_ni, .d_i(ad_i), .q_o(ad_s), .prev_o(ad_p));

  mbr_pwr_gate #(.DELAY_CYC(PWR_DELAY_CYC)) u_pwr (
    .clk_i, .rst_ni, .pwr_good_i, .ok_o(ok));

  assign as_fall = stb_p[3] & ~stb_s[3];
  assign wr_rise = ~stb_p[1] & stb_s[1];
  assign cs_act  = ~stb_s[0] & ok;
  assign host_we = wr_rise & cs_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             addr_q <= '0;
    else if (as_fall && ok)  addr_q <= ad_s[AW-1:0];
  end

  mbr_store u_store (
    .clk_i, .rst_ni,
    .clr_i      (ram_clr_i),
    .host_we_i  (host_we),
    .host_addr_i(addr_q),
    .host_data_i(ad_s),
    .upd_we_i, .upd_addr_i, .upd_data_i,
    .rdata_o    (rdata),
    .clk_regs_o
  );

  assign ad_oe_o = cs_act & ~stb_s[2];
  assign ad_o    = ad_oe_o ? rdata : 8'h00;

  // R9
  oe_needs_power_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> pwr_good_i || $past(pwr_good_i));
  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_fall |=> $stable(addr_q));
  // R4
  no_write_unselected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_s[0] |-> !host_we);
endmodule

// File: tb/sim_mux_bus_regfile.sv
module sim_mux_bus_regfile;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned DLY = 40;

  typedef struct {
    logic       oe;
    logic [7:0] data;
    string      req;
  } exp_t;

  logic clk = 0, rst_n = 0, pg = 1, clr = 0;
  logic [7:0] ad = 0;
  logic as_s = 0, rd_n = 1, wr_n = 1, cs_n = 1;
  logic upd_we = 0;
  logic [3:0] upd_addr = 0;
  logic [7:0] upd_data = 0;
  logic [7:0] ad_o;
  logic ad_oe;
  logic [111:0] regs;
  logic smp_req = 0;
  int checks = 0, errors = 0;
  exp_t q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_regfile #(.PWR_DELAY_CYC(DLY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg), .ram_clr_i(clr),
    .ad_i(ad), .ad_o(ad_o), .ad_oe_o(ad_oe), .as_i(as_s), .rd_ni(rd_n),
    .wr_ni(wr_n), .cs_ni(cs_n), .upd_we_i(upd_we), .upd_addr_i(upd_addr),
    .upd_data_i(upd_data), .clk_regs_o(regs));

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop expected read results
  always @(negedge clk) if (smp_req) begin
    exp_t e;
    if (q.size() == 0) chk(0, "queue", 8'h00, 8'h00);
    else begin
      e = q.pop_front();
      chk(ad_oe === e.oe, e.req, {7'd0, ad_oe}, {7'd0, e.oe});
      if (e.oe) chk(ad_o === e.data, e.req, ad_o, e.data);
    end
  end

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic addr_phase(input logic [7:0] a, input logic cs);
    cs_n = cs; ad = a; as_s = 1; cyc(4);
    as_s = 0; cyc(4);
  endtask

  task automatic wr_phase(input logic [7:0] d, input logic cs);
    cs_n = cs; ad = d; wr_n = 0; cyc(4);
    wr_n = 1; cyc(4); cs_n = 1;
  endtask

  task automatic rd_phase(input logic cs, input logic oe, input logic [7:0] d, input string req);
    exp_t e;
    e.oe = oe; e.data = d; e.req = req;
    q.push_back(e);
    cs_n = cs; ad = 8'h00; rd_n = 0; cyc(4);
    @(posedge clk); smp_req <= 1; @(posedge clk); smp_req <= 0;
    cyc(1); rd_n = 1; cyc(3); cs_n = 1;
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [7:0] d);
    addr_phase(a, 0); wr_phase(d, 0);
  endtask

  task automatic bread(input logic [7:0] a, input logic [7:0] d, input string req);
    addr_phase(a, 0); rd_phase(0, 1, d, req);
  endtask

  function automatic logic [7:0] cb(input int i); return regs[i*8 +: 8]; endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    cyc(3);
    // R1
    chk(ad_oe === 0, "R1 oe", {7'd0, ad_oe}, 8'h00);
    chk(regs === '0, "R1 regs", regs[7:0], 8'h00);
    rst_n = 1;
    // R10: write inside hold-off window is dropped
    bwrite(8'h30, 8'h5a);
    cyc(DLY + 10);
    bread(8'h30, 8'h00, "R10 hold-off");
    // R3 / R4
    bwrite(8'h20, 8'ha5);
    bwrite(8'h7f, 8'h3c);
    bread(8'h20, 8'ha5, "R3 rw 0x20");
    bread(8'h7f, 8'h3c, "R3 rw 0x7f");
    // R2: bit 7 dropped
    bwrite(8'h85, 8'h11);
    bread(8'h05, 8'h11, "R2 7-bit addr");
    chk(cb(5) === 8'h11, "R8 byte5", cb(5), 8'h11);
    // R4: unselected
    addr_phase(8'h20, 1); wr_phase(8'hee, 1);
    addr_phase(8'h20, 1); rd_phase(1, 0, 8'h00, "R4 cs high read");
    bread(8'h20, 8'ha5, "R4 cs high write dropped");
    // R5: address latched with cs high
    addr_phase(8'h21, 1); wr_phase(8'h77, 0);
    bread(8'h21, 8'h77, "R5 latch w/o cs");
    // R6
    bwrite(8'd12, 8'hff); bwrite(8'd13, 8'hff);
    bwrite(8'd10, 8'hff); bwrite(8'd0, 8'hff);
    chk(cb(12) === 8'h00, "R6 byte12", cb(12), 8'h00);
    chk(cb(13) === 8'h00, "R6 byte13", cb(13), 8'h00);
    chk(cb(10) === 8'h7f, "R6 byte10", cb(10), 8'h7f);
    chk(cb(0) === 8'h7f, "R6 byte0", cb(0), 8'h7f);
    // R7
    @(negedge clk); upd_we = 1; upd_addr = 4'd12; upd_data = 8'hc3;
    @(negedge clk); upd_addr = 4'd10; upd_data = 8'h80;
    @(negedge clk); upd_we = 0;
    chk(cb(12) === 8'hc3, "R7 upd byte12", cb(12), 8'hc3);
    chk(cb(10) === 8'h80, "R7 upd byte10", cb(10), 8'h80);
    bread(8'd12, 8'hc3, "R7 read back");
    bwrite(8'd10, 8'h00);
    chk(cb(10) === 8'h80, "R6 bit7 kept", cb(10), 8'h80);
    // R8
    bwrite(8'd3, 8'h42);
    chk(cb(3) === 8'h42, "R8 byte3", cb(3), 8'h42);
    // R9
    pg = 0; cyc(2);
    bwrite(8'h31, 8'haa);
    addr_phase(8'h20, 0); rd_phase(0, 0, 8'h00, "R9 read blocked");
    pg = 1; cyc(DLY + 10);
    bread(8'h31, 8'h00, "R9 write blocked");
    bread(8'h20, 8'ha5, "R9 addr not latched");
    // R11
    @(negedge clk); clr = 1; @(negedge clk); clr = 0; cyc(2);
    bread(8'h20, 8'hff, "R11 user 0x20");
    bread(8'd14, 8'hff, "R11 user 14");
    chk(cb(3) === 8'h42, "R11 clock kept", cb(3), 8'h42);
    chk(cb(12) === 8'hc3, "R11 clock12 kept", cb(12), 8'hc3);
    cyc(5);
    chk(q.size() == 0, "scoreboard drained", 8'(q.size()), 8'h00);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule